// File: doc/BRIEF.md
# SerDes PHY Interrupt Status Controller

This block collects eight event pulses from a serial gigabit PHY into a sticky status register. The events are coding and disparity errors, PLL loss of lock, and link-negotiation progress and faults. A mask register selects which captured events drive a single registered interrupt line. Software reaches the block over a plain synchronous register bus made of an address, a write strobe, write data and combinational read data.

Clearing is a handshake, not a write-one-to-clear. Software first loads a clear-select register with the bits it wants cleared. It then sets bit 0 of a command register. While that bit stays set, a countdown runs, and after a fixed latency the selected status bits drop. Software polls the status register until those bits read zero. It then writes zero to the command register and then to the clear-select register.

Top module: `serdes_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, status, mask, clear-select and command all read zero and `irq_o` is low.
- R2: A high `ev_i[i]` at a rising edge sets status bit i at that edge, and the bit stays set until it is cleared. The bit meanings are: 7 code-group error, 6 disparity error, 5 PLL unlock, 4 illegal negotiation end, 3 sync loss, 2 negotiation start, 1 negotiation done, 0 negotiation request.
- R3: `irq_o` equals the OR of (status AND mask) as it stood before the previous rising edge, so it lags the status by one edge. While the mask is zero, `irq_o` stays low.
- R4: Writing to clear-select while command bit 0 is low never changes the status.
- R5: Suppose command bit 0 is written to 1 at edge E0 and clear-select is nonzero. The selected status bits then still read 1 after E0+1, E0+2 and E0+3, and read 0 after edge E0+CLR_LAT+1, which is E0+4 by default.
- R6: Status bits not selected in clear-select keep their value through a clear.
- R7: An event that arrives at the same edge at which its bit is cleared wins, so the bit stays set.
- R8: One command performs at most one clear. Events that arrive after the clear, while bit 0 stays set, remain captured. Writing bit 0 to 0 and then to 1 again starts a new clear.
- R9: If command bit 0 is written to 0 before the countdown completes, no status bit is cleared.
- R10: The address map is: 0 status (read-only, writes ignored), 1 mask, 2 clear-select, 3 command (only bit 0 is stored, and the other bits read 0). Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | N_SRC | Event pulses, one per status bit |
| addr_i | input | AW | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | N_SRC | Write data |
| rd_data_o | output | N_SRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered, masked interrupt |

## Verification
Sparse random event pulses are mixed with random writes to the mask, to clear-select and to the read-only status address. This tells apart correct sticky capture and one-edge interrupt lag from designs where stray writes or a missing mask term leak through. Directed clear sequences check the exact edge at which bits drop. They also cover an event that collides with the clearing edge, a command released mid-countdown, and a command held after the clear completes. Together these separate an early, late or repeated clear, and a clear that touches unselected bits.

// File: rtl/sirq_pkg.sv
// Package: shared register addresses and clear sequencer states.
// Assumes the command register uses bit 0 as the global clear bit.
package sirq_pkg;
    localparam int A_STATUS = 0;
    localparam int A_MASK   = 1;
    localparam int A_CLRSEL = 2;
    localparam int A_CMD    = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_HOLD  = 2'd2
    } clr_state_e;
endpackage

// File: rtl/sirq_regs.sv
// Register file: holds mask, clear-select and command bit, and drives the read mux.
// Assumes single-cycle writes and a combinational read path.
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_en_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic [N_SRC-1:0] status_i,
    output logic [N_SRC-1:0] mask_o,
    output logic [N_SRC-1:0] clrsel_o,
    output logic             cmd_o,
    output logic [N_SRC-1:0] rd_data_o
);
    // Write path for the software-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '0;
            clrsel_o <= '0;
            cmd_o    <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == AW'(A_MASK))   mask_o   <= wr_data_i;
            if (addr_i == AW'(A_CLRSEL)) clrsel_o <= wr_data_i;
            if (addr_i == AW'(A_CMD))    cmd_o    <= wr_data_i[0];
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rd_data_o = '0;
        if (addr_i == AW'(A_STATUS))      rd_data_o = status_i;
        else if (addr_i == AW'(A_MASK))   rd_data_o = mask_o;
        else if (addr_i == AW'(A_CLRSEL)) rd_data_o = clrsel_o;
        else if (addr_i == AW'(A_CMD))    rd_data_o = {{(N_SRC-1){1'b0}}, cmd_o};
    end

    a_r10_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(A_CMD)) |=> (cmd_o == $past(wr_data_i[0])));
endmodule

// File: rtl/sirq_clrseq.sv
// Clear sequencer: counts CLR_LAT cycles of a held command, then fires once.
// Assumes the command bit and clear-select come from registers.
module sirq_clrseq
    import sirq_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int CLR_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic [N_SRC-1:0] clrsel_i,
    output logic             fire_o
);
    localparam int CW = (CLR_LAT > 1) ? $clog2(CLR_LAT) : 1;

    clr_state_e    st_q;
    logic [CW-1:0] cnt_q;

    // State and countdown; releasing the command aborts or re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (cmd_i && (|clrsel_i)) begin
                    st_q  <= S_COUNT;
                    cnt_q <= '0;
                end
                S_COUNT: if (!cmd_i) st_q <= S_IDLE;
                    else if (cnt_q == CW'(CLR_LAT-1)) st_q <= S_HOLD;
                    else cnt_q <= cnt_q + 1'b1;
                S_HOLD: if (!cmd_i) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // One-cycle clear strobe at the end of the countdown.
    always_comb fire_o = (st_q == S_COUNT) && cmd_i && (cnt_q == CW'(CLR_LAT-1));

    a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    a_r9_fire_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (cmd_i && (|clrsel_i)));
endmodule

// File: rtl/sirq_status.sv
// Sticky status capture: events set bits, a fire strobe clears selected bits.
// Assumes an event outranks a clear on the same edge.
module sirq_status #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev_i,
    input  logic             fire_i,
    input  logic [N_SRC-1:0] clrsel_i,
    output logic [N_SRC-1:0] status_o
);
    // Per-bit capture with event priority.
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                       status_o[i] <= 1'b0;
            else if (ev_i[i])                 status_o[i] <= 1'b1;
            else if (fire_i && clrsel_i[i])   status_o[i] <= 1'b0;
        end

        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> status_o[i]);
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[i] && !(fire_i && clrsel_i[i])) |=> status_o[i]);
    end
endmodule

// File: rtl/serdes_irq_ctrl.sv
// Top: SerDes PHY interrupt status controller with handshake clearing.
// Assumes the bus is in the same clock domain and events are synchronous pulses.
module serdes_irq_ctrl #(
    parameter int N_SRC   = 8,
    parameter int AW      = 4,
    parameter int CLR_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_en_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] rd_data_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] status_q, mask_q, clrsel_q;
    logic             cmd_q, fire;

    sirq_regs #(.N_SRC(N_SRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .status_i(status_q), .mask_o(mask_q),
        .clrsel_o(clrsel_q), .cmd_o(cmd_q), .rd_data_o(rd_data_o)
    );

    sirq_clrseq #(.N_SRC(N_SRC), .CLR_LAT(CLR_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_q), .clrsel_i(clrsel_q), .fire_o(fire)
    );

    sirq_status #(.N_SRC(N_SRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .fire_i(fire),
        .clrsel_i(clrsel_q), .status_o(status_q)
    );

    // Registered masked interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status_q & mask_q);
    end

    a_r3_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask_q)) |=> irq_o);
    a_r3_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_o);
endmodule

// File: tb/tb_serdes_irq_ctrl.sv
module tb_serdes_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_i = '0;
    logic [3:0] addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_status = '0, exp_mask = '0;
    logic       exp_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdes_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] next_status(input logic [7:0] s, input logic [7:0] e,
                                               input logic [7:0] clr);
        return (s & ~clr) | e;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        addr_i = a;
        #1;
        chk(tag, rd_data_o, exp);
    endtask

    // One clock: drive at negedge, update the model after the edge.
    task automatic step(input logic [7:0] e, input logic we, input logic [3:0] a,
                        input logic [7:0] d, input logic [7:0] clr);
        ev_i = e; wr_en_i = we; addr_i = a; wr_data_i = d;
        @(posedge clk);
        exp_irq = |(exp_status & exp_mask);
        exp_status = next_status(exp_status, e, clr);
        if (we && a == 4'd1) exp_mask = d;
        @(negedge clk);
        ev_i = '0; wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 1'b0, 4'd0, 8'h00, 8'h00);
    endtask

    // Full handshake clear with no events in flight.
    task automatic do_clear(input logic [7:0] sel);
        step(8'h00, 1'b1, 4'd2, sel, 8'h00);
        step(8'h00, 1'b1, 4'd3, 8'h01, 8'h00);
        idle(LAT);
        step(8'h00, 1'b0, 4'd0, 8'h00, sel);
        step(8'h00, 1'b1, 4'd3, 8'h00, 8'h00);
        step(8'h00, 1'b1, 4'd2, 8'h00, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 8'h00, "R1 status"); rd(4'd1, 8'h00, "R1 mask");
        rd(4'd2, 8'h00, "R1 clrsel"); rd(4'd3, 8'h00, "R1 cmd");
        chk("R1 irq", {7'd0, irq_o}, 8'h00);

        // R2 capture per bit, R3 masked interrupt lag
        step(8'h24, 1'b0, 4'd0, 8'h00, 8'h00);
        rd(4'd0, 8'h24, "R2 capture");
        chk("R3 irq masked off", {7'd0, irq_o}, 8'h00);
        step(8'h00, 1'b1, 4'd1, 8'h04, 8'h00);
        rd(4'd1, 8'h04, "R10 mask readback");
        chk("R3 irq lag", {7'd0, irq_o}, 8'h00);
        idle(1);
        chk("R3 irq set", {7'd0, irq_o}, 8'h01);
        step(8'h00, 1'b1, 4'd1, 8'h00, 8'h00);
        idle(1);
        chk("R3 zero mask", {7'd0, irq_o}, 8'h00);

        // R10 map corners
        step(8'h00, 1'b1, 4'd0, 8'h00, 8'h00);
        rd(4'd0, 8'h24, "R10 status write ignored");
        step(8'h00, 1'b1, 4'd3, 8'hFE, 8'h00);
        rd(4'd3, 8'h00, "R10 cmd only bit0");
        rd(4'd7, 8'h00, "R10 unmapped");

        // R4 clear-select without command
        step(8'hFF, 1'b1, 4'd2, 8'hFF, 8'h00);
        idle(LAT + 2);
        rd(4'd0, 8'hFF, "R4 no command no clear");

        // R5 latency and R6 unselected bits (error group)
        step(8'h00, 1'b1, 4'd2, 8'hC0, 8'h00);
        step(8'h00, 1'b1, 4'd3, 8'h01, 8'h00);
        for (int k = 1; k <= LAT; k++) begin
            idle(1);
            rd(4'd0, 8'hFF, $sformatf("R5 still set after E0+%0d", k));
        end
        idle(1);
        rd(4'd0, 8'h3F, "R5 cleared at E0+4 / R6 others kept");

        // R8 held command does not clear again
        step(8'h40, 1'b0, 4'd0, 8'h00, 8'h00);
        idle(LAT + 3);
        rd(4'd0, 8'h7F, "R8 held command no second clear");
        step(8'h00, 1'b1, 4'd3, 8'h00, 8'h00);
        step(8'h00, 1'b1, 4'd3, 8'h01, 8'h00);
        idle(LAT);
        rd(4'd0, 8'h7F, "R8 rearm not yet");
        idle(1);
        rd(4'd0, 8'h3F, "R8 rearm clears");
        step(8'h00, 1'b1, 4'd3, 8'h00, 8'h00);
        exp_status = 8'h3F;

        // R7 event on the clearing edge wins
        step(8'hC0, 1'b0, 4'd0, 8'h00, 8'h00);
        step(8'h00, 1'b1, 4'd3, 8'h01, 8'h00);
        idle(LAT);
        step(8'h80, 1'b0, 4'd0, 8'h00, 8'h00);
        rd(4'd0, 8'hBF, "R7 event beats clear");
        step(8'h00, 1'b1, 4'd3, 8'h00, 8'h00);

        // R9 command released mid-countdown
        step(8'h00, 1'b1, 4'd2, 8'hFF, 8'h00);
        step(8'h00, 1'b1, 4'd3, 8'h01, 8'h00);
        idle(1);
        step(8'h00, 1'b1, 4'd3, 8'h00, 8'h00);
        idle(LAT + 3);
        rd(4'd0, 8'hBF, "R9 abort keeps status");
        exp_status = 8'hBF;
        do_clear(8'hFF);
        rd(4'd0, 8'h00, "R5 full clear");

        // Random rounds: R2 capture, R3 irq, R4 and R10 stray writes
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 60; i++) begin
                logic [7:0] e;
                logic [3:0] a;
                e = 8'($urandom & $urandom & $urandom);
                a = 4'($urandom % 3);
                step(e, 1'($urandom), a, 8'($urandom), 8'h00);
                rd(4'd0, exp_status, "R2 random status");
                chk("R3 random irq", {7'd0, irq_o}, {7'd0, exp_irq});
            end
            do_clear(8'hFF);
            rd(4'd0, 8'h00, "R6 round clear");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule